// File: doc/BRIEF.md
# Semaphore Access Error Capture

This block collects access-violation reports from every semaphore cell of a hardware lock bank and keeps one error record for software. The record says which master misbehaved, on which semaphore, and how: releasing a lock nobody holds, releasing a lock held by another master, acquiring a lock the same master already holds, or posting a second request while one is still pending. Only the first error is kept. Later reports are dropped until software clears the record.

When an error is latched, the block pulses the error interrupt line of the master that caused it. That line is then disarmed. Every line is armed again by a single end-of-interrupt write that carries the re-arm-all-errors code. Software reads the record at its own offset, clears it by writing to the clear offset, and then writes the end-of-interrupt code. Register reads are combinational on the address. Writes take effect at the next rising clock edge.

Top module: `sem_err_capture`

## Requirements
- R1: After reset the record reads as all zeros and every error interrupt line is low.
- R2: A read at offset 0x500 returns the record: bits 2:0 hold the error code, bits 7:3 the semaphore number, bits 15:8 the master ID, and bits 31:16 read as zero. A read at any other offset returns zero.
- R3: A reported event with code 1 (release of a free lock), 2 (release of a lock owned by another master), 3 (re-acquire by the owner) or 4 (request while a request is pending) is latched and visible one clock after it is presented. An event with code 0 or with code 5 to 7 is ignored.
- R4: While the record holds a non-zero code, new events change neither the record nor any interrupt line.
- R5: When several semaphores report legal events in the same cycle, the record takes the lowest-numbered one. Ignored codes at lower numbers do not block it.
- R6: Any write to offset 0x504 returns the record to all zeros. An event presented in the same cycle as that write is dropped.
- R7: A latched error raises err_irq[master ID] for exactly one cycle, the same cycle in which the record first shows it. All other lines stay low. A master ID at or above the number of masters raises no line.
- R8: After a line has pulsed, further errors from that master raise no pulse until the lines are re-armed.
- R9: A write to offset 0x00C whose bits 7:0 equal 0x10 re-arms every line, whatever bits 31:8 hold. Other values in bits 7:0, such as a per-master interrupt select, do not re-arm the error lines.
- R10: Arming is tracked per master, so a disarmed line never suppresses the pulse of another master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_valid | input | NUM_SEM | Per-semaphore error report strobe |
| ev_code | input | NUM_SEM*3 | Per-semaphore error code, 3 bits per semaphore |
| ev_mid | input | NUM_SEM*MID_W | Per-semaphore offending master ID |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset for reads and writes |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational on bus_addr |
| err_irq | output | NUM_MST | Per-master error interrupt pulse |

## Verification
The bench aims at the cases where the priority logic is easy to get wrong:
- A legal event that sits above an illegal one in the same cycle. A picker that uses the raw strobes would latch nothing or latch the illegal code.
- An event presented during a clear write. A design that lets capture beat clear would leave a non-zero record behind.
- A held record hit by a new event. A design that lets the latest report win would overwrite the first error or pulse a line a second time.

The re-arm tests cover three further faults:
- A per-master select code that wrongly re-arms the error lines.
- An ignored upper data byte that is wrongly decoded.
- A master ID outside the line count. A wrong design would raise a stray line or index out of range.

// File: rtl/sem_err_pkg.sv
package sem_err_pkg;

   localparam int CODE_W = 3;
   localparam int REC_W  = 32;

   typedef enum logic [CODE_W-1:0] {
      ERR_NONE        = 3'd0,
      ERR_FREE_REL    = 3'd1,
      ERR_FOREIGN_REL = 3'd2,
      ERR_REACQUIRE   = 3'd3,
      ERR_DOUBLE_REQ  = 3'd4
   } err_code_e;

   function automatic logic code_is_legal(input logic [CODE_W-1:0] c);
      return (c >= ERR_FREE_REL) && (c <= ERR_DOUBLE_REQ);
   endfunction

endpackage

// File: rtl/sem_err_pick.sv
module sem_err_pick #(
   parameter int NUM_SEM = 32,
   parameter int SEM_W   = $clog2(NUM_SEM)
) (
   input  logic [NUM_SEM-1:0] qual,
   output logic               pick_valid,
   output logic [SEM_W-1:0]   pick_idx
);

   always_comb begin
      pick_idx = '0;
      for (int i = NUM_SEM - 1; i >= 0; i--) begin
         if (qual[i]) pick_idx = SEM_W'(i);
      end
   end

   assign pick_valid = |qual;

   always_comb begin
      if (pick_valid) begin
         AST_PICK_IS_REQUESTER: assert (qual[pick_idx]); // R5
      end
   end

endmodule

// File: rtl/sem_err_record.sv
module sem_err_record
   import sem_err_pkg::*;
#(
   parameter int SEM_W = 5,
   parameter int MID_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_req,
   input  logic [CODE_W-1:0] cap_code,
   input  logic [SEM_W-1:0]  cap_sem,
   input  logic [MID_W-1:0]  cap_mid,
   input  logic              clr,
   output logic              accepted,
   output logic [CODE_W-1:0] rec_code,
   output logic [SEM_W-1:0]  rec_sem,
   output logic [MID_W-1:0]  rec_mid
);

   logic empty;

   assign empty    = (rec_code == ERR_NONE);
   assign accepted = cap_req && empty && !clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rec_code <= ERR_NONE;
         rec_sem  <= '0;
         rec_mid  <= '0;
      end else if (clr) begin
         rec_code <= ERR_NONE;
         rec_sem  <= '0;
         rec_mid  <= '0;
      end else if (accepted) begin
         rec_code <= cap_code;
         rec_sem  <= cap_sem;
         rec_mid  <= cap_mid;
      end
   end

   AST_FIRST_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (!empty && !clr) |=> ($stable(rec_code) && $stable(rec_sem) && $stable(rec_mid))); // R4

   AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (rec_code == ERR_NONE && rec_sem == '0 && rec_mid == '0)); // R6

endmodule

// File: rtl/sem_err_irq.sv
module sem_err_irq #(
   parameter int NUM_MST = 3,
   parameter int MID_W   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fire,
   input  logic [MID_W-1:0]   fire_mid,
   input  logic               rearm,
   output logic [NUM_MST-1:0] irq
);

   logic [NUM_MST-1:0] armed;

   for (genvar m = 0; m < NUM_MST; m++) begin : g_line
      logic hit;
      assign hit = fire && (fire_mid == MID_W'(m));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            armed[m] <= 1'b1;
            irq[m]   <= 1'b0;
         end else begin
            irq[m] <= hit && armed[m];
            if (hit)        armed[m] <= 1'b0;
            else if (rearm) armed[m] <= 1'b1;
         end
      end

      AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
         irq[m] |=> !irq[m]); // R7

      AST_DISARMED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
         (!armed[m] && !rearm) |=> !irq[m]); // R8
   end

endmodule

// File: rtl/sem_err_capture.sv
module sem_err_capture
   import sem_err_pkg::*;
#(
   parameter int               NUM_SEM   = 32,
   parameter int               NUM_MST   = 3,
   parameter int               MID_W     = 8,
   parameter int               ADDR_W    = 11,
   parameter logic [ADDR_W-1:0] REC_OFS  = 11'h500,
   parameter logic [ADDR_W-1:0] CLR_OFS  = 11'h504,
   parameter logic [ADDR_W-1:0] EOI_OFS  = 11'h00C,
   parameter logic [7:0]       REARM_ALL = 8'h10
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_SEM-1:0]       ev_valid,
   input  logic [NUM_SEM*3-1:0]     ev_code,
   input  logic [NUM_SEM*MID_W-1:0] ev_mid,
   input  logic                     bus_wr,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [31:0]              bus_wdata,
   output logic [31:0]              bus_rdata,
   output logic [NUM_MST-1:0]       err_irq
);

   localparam int SEM_W   = $clog2(NUM_SEM);
   localparam int SEM_LSB = CODE_W;
   localparam int MID_LSB = 8;

   if (NUM_SEM < 2 || SEM_W > MID_LSB - SEM_LSB) begin : g_bad_sem
      $error("sem_err_capture: NUM_SEM must be 2..32");
   end
   if (MID_W < 1 || MID_W > 8) begin : g_bad_mid
      $error("sem_err_capture: MID_W must be 1..8");
   end
   if (NUM_MST < 1 || NUM_MST > (1 << MID_W)) begin : g_bad_mst
      $error("sem_err_capture: NUM_MST does not fit MID_W");
   end

   logic [NUM_SEM-1:0] qual;
   logic               pick_valid;
   logic [SEM_W-1:0]   pick_idx;
   logic [CODE_W-1:0]  pick_code;
   logic [MID_W-1:0]   pick_mid;
   logic               clr_hit, rearm_hit, accepted;
   logic [CODE_W-1:0]  rec_code;
   logic [SEM_W-1:0]   rec_sem;
   logic [MID_W-1:0]   rec_mid;
   logic [REC_W-1:0]   rec_word;

   for (genvar s = 0; s < NUM_SEM; s++) begin : g_qual
      assign qual[s] = ev_valid[s] && code_is_legal(ev_code[s*CODE_W +: CODE_W]);
   end

   sem_err_pick #(.NUM_SEM(NUM_SEM), .SEM_W(SEM_W)) u_pick (
      .qual       (qual),
      .pick_valid (pick_valid),
      .pick_idx   (pick_idx)
   );

   assign pick_code = ev_code[int'(pick_idx)*CODE_W +: CODE_W];
   assign pick_mid  = ev_mid[int'(pick_idx)*MID_W +: MID_W];

   assign clr_hit   = bus_wr && (bus_addr == CLR_OFS);
   assign rearm_hit = bus_wr && (bus_addr == EOI_OFS) && (bus_wdata[7:0] == REARM_ALL);

   sem_err_record #(.SEM_W(SEM_W), .MID_W(MID_W)) u_rec (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_req  (pick_valid),
      .cap_code (pick_code),
      .cap_sem  (pick_idx),
      .cap_mid  (pick_mid),
      .clr      (clr_hit),
      .accepted (accepted),
      .rec_code (rec_code),
      .rec_sem  (rec_sem),
      .rec_mid  (rec_mid)
   );

   sem_err_irq #(.NUM_MST(NUM_MST), .MID_W(MID_W)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire     (accepted),
      .fire_mid (pick_mid),
      .rearm    (rearm_hit),
      .irq      (err_irq)
   );

   always_comb begin
      rec_word                    = '0;
      rec_word[CODE_W-1:0]        = rec_code;
      rec_word[SEM_LSB +: SEM_W]  = rec_sem;
      rec_word[MID_LSB +: MID_W]  = rec_mid;
   end

   assign bus_rdata = (bus_addr == REC_OFS) ? rec_word : '0;

   AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(err_irq)); // R7

   for (genvar m = 0; m < NUM_MST; m++) begin : g_chk
      AST_LINE_MATCHES_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
         err_irq[m] |-> (rec_mid == MID_W'(m) && rec_code != ERR_NONE)); // R7
   end

endmodule

// File: tb/sem_err_capture_tb.sv
module sem_err_capture_tb;

   localparam int NS = 32;
   localparam int NM = 3;
   localparam int MW = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NS-1:0]    ev_valid = '0;
   logic [NS*3-1:0]  ev_code = '0;
   logic [NS*MW-1:0] ev_mid = '0;
   logic           bus_wr = 1'b0;
   logic [10:0]    bus_addr = 11'h500;
   logic [31:0]    bus_wdata = '0;
   logic [31:0]    bus_rdata;
   logic [NM-1:0]  err_irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   sem_err_capture u_dut (
      .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_code(ev_code),
      .ev_mid(ev_mid), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .err_irq(err_irq)
   );

   typedef struct packed {
      logic [4:0]  sa; logic [2:0] ca; logic [7:0] ma;
      logic        vb;
      logic [4:0]  sb; logic [2:0] cb; logic [7:0] mb;
      logic [31:0] exp_rec;
      logic [2:0]  exp_irq;
   } vec_t;

   localparam vec_t VT [9] = '{
      '{5'd5,  3'd1, 8'd0, 1'b0, 5'd0,  3'd0, 8'd0, 32'h0000_0029, 3'b001},
      '{5'd31, 3'd2, 8'd2, 1'b0, 5'd0,  3'd0, 8'd0, 32'h0000_02FA, 3'b100},
      '{5'd0,  3'd3, 8'd1, 1'b0, 5'd0,  3'd0, 8'd0, 32'h0000_0103, 3'b010},
      '{5'd12, 3'd4, 8'd2, 1'b1, 5'd7,  3'd1, 8'd1, 32'h0000_0139, 3'b010},
      '{5'd3,  3'd0, 8'd1, 1'b0, 5'd0,  3'd0, 8'd0, 32'h0000_0000, 3'b000},
      '{5'd9,  3'd6, 8'd0, 1'b0, 5'd0,  3'd0, 8'd0, 32'h0000_0000, 3'b000},
      '{5'd2,  3'd5, 8'd1, 1'b1, 5'd20, 3'd2, 8'd0, 32'h0000_00A2, 3'b001},
      '{5'd14, 3'd1, 8'd5, 1'b0, 5'd0,  3'd0, 8'd0, 32'h0000_0571, 3'b000},
      '{5'd6,  3'd2, 8'd2, 1'b1, 5'd1,  3'd0, 8'd0, 32'h0000_0232, 3'b100}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   task automatic put_ev(input int s, input logic [2:0] c, input logic [7:0] m);
      ev_valid[s]          = 1'b1;
      ev_code[s*3 +: 3]    = c;
      ev_mid[s*MW +: MW]   = m;
   endtask

   // Drives the events present for one clock, then samples at the next negedge.
   task automatic pulse_ev();
      @(negedge clk);
      ev_valid = '0;
      ev_code  = '0;
      ev_mid   = '0;
   endtask

   task automatic wr(input logic [10:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = 11'h500; bus_wdata = '0;
   endtask

   task automatic one_err(input logic [7:0] m);
      put_ev(4, 3'd1, m);
      pulse_ev();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 record after reset", bus_rdata, 32'h0);
      chk("R1 irq after reset", 32'(err_irq), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 record after release", bus_rdata, 32'h0);

      // Vector table: R2 R3 R5 R7
      foreach (VT[i]) begin
         wr(11'h504, 32'h0);
         wr(11'h00C, 32'h10);
         put_ev(VT[i].sa, VT[i].ca, VT[i].ma);
         if (VT[i].vb) put_ev(VT[i].sb, VT[i].cb, VT[i].mb);
         pulse_ev();
         chk($sformatf("R3 R5 R2 record vec %0d", i), bus_rdata, VT[i].exp_rec);
         chk($sformatf("R7 irq vec %0d", i), 32'(err_irq), 32'(VT[i].exp_irq));
         @(negedge clk);
         chk($sformatf("R7 irq drops vec %0d", i), 32'(err_irq), 32'h0);
      end

      // R4: held record ignores new events
      put_ev(1, 3'd1, 8'd0);
      pulse_ev();
      chk("R4 record kept", bus_rdata, 32'h0000_0232);
      chk("R4 no irq", 32'(err_irq), 32'h0);

      // R2: other offset reads zero
      bus_addr = 11'h504; #1;
      chk("R2 other offset reads zero", bus_rdata, 32'h0);
      bus_addr = 11'h500;

      // R6: clear concurrent with event drops the event
      bus_wr = 1'b1; bus_addr = 11'h504; bus_wdata = 32'hFFFF_FFFF;
      put_ev(3, 3'd2, 8'd1);
      pulse_ev();
      bus_wr = 1'b0; bus_addr = 11'h500; bus_wdata = '0;
      #1;
      chk("R6 clear wins", bus_rdata, 32'h0);
      chk("R6 no irq", 32'(err_irq), 32'h0);

      // R8 / R10 / R9 arming sequence
      wr(11'h00C, 32'h10);
      one_err(8'd0);
      chk("R8 first pulse master0", 32'(err_irq), 32'h1);
      wr(11'h504, 32'h0);
      one_err(8'd0);
      chk("R8 disarmed master0 silent", 32'(err_irq), 32'h0);
      chk("R8 record still captured", bus_rdata, 32'h0000_0021);
      wr(11'h504, 32'h0);
      one_err(8'd1);
      chk("R10 master1 still armed", 32'(err_irq), 32'h2);
      wr(11'h504, 32'h0);
      wr(11'h00C, 32'h01);
      one_err(8'd0);
      chk("R9 select code does not rearm", 32'(err_irq), 32'h0);
      wr(11'h504, 32'h0);
      wr(11'h00C, 32'hABCD_EF10);
      one_err(8'd0);
      chk("R9 rearm with upper bits set", 32'(err_irq), 32'h1);

      finish_run();
   end

endmodule